// File: doc/BRIEF.md
# Compressed Branch Next-Address Unit

This unit sits beside the decoder of a core that runs a 16-bit compressed instruction set. Each cycle the decoder presents one instruction: its address, a small operation code, the raw offset field, the two halfwords of a long call, and the values of the source register, the return-address register and a dedicated test register. The unit returns the address to fetch next, the instruction-set mode bit carried in the low bit of jump targets, and the return address with its write enable. It also returns the base address for PC-relative loads and address generation, and the address that a break trap reports.

Jumps and calls have one delay slot. The jump itself sends fetch to the slot address and arms an internal slot state that holds the target. The instruction in the slot then sends fetch to the held target. While the slot is armed, PC-relative arithmetic and break reporting refer back to the jump and not to the slot instruction. A branch or jump that arrives in the slot is reported as illegal and does not start a new slot.

Top module: `bnpc_top`

## Requirements
- R1: After reset, `in_dslot`, `ret_we` and `illegal` are 0. With no instruction issued and `op_code` 0, `next_pc` is `pc_cur`+2 and `mode_bit` is 1.
- R2: Operation codes are 0 sequential, 1 branch-if-zero, 2 branch-if-nonzero, 3 test-zero branch, 4 test-nonzero branch, 5 unconditional branch, 6 long call, 7 mode-switch call, 8 register jump, 9 return jump, 10 register call, 11 break, 12 word PC-relative and 13 doubleword PC-relative. An unknown code acts as sequential. The fall-through address is `pc_cur`+4 when `is_ext`=1 or the code is 6 or 7, and `pc_cur`+2 otherwise. With no slot armed, a non-jump gives `mode_bit`=1.
- R3: Codes 1 and 2 test `rs_val` for zero or nonzero. When taken, `next_pc` is the fall-through address plus twice the offset. The offset is `imm_field[7:0]` sign-extended, or all 16 bits sign-extended when `is_ext`=1. When not taken, `next_pc` is the fall-through address.
- R4: Codes 3 and 4 test `t8_val` for zero or nonzero, and `rs_val` has no effect on them.
- R5: Code 5 is always taken. It uses `imm_field[10:0]` sign-extended, or 16 bits when `is_ext`=1, times two.
- R6: For codes 6 and 7 the 26-bit field is {`call_hw0[4:0]`, `call_hw0[9:5]`, `call_hw1`}, holding bits 25:21, 20:16 and 15:0. The target is the fall-through address bits 31:28 joined with the field shifted left by 2. Its low bit is 1 for code 6 and 0 for code 7. The return address is the fall-through address plus 2.
- R7: Code 8 targets `rs_val`, code 9 targets `ra_val` and code 10 targets `rs_val`. Code 10 writes the return address, which is the fall-through address plus 2. For every jump, the low bit of the target becomes `mode_bit` and `next_pc` has bit 0 cleared.
- R8: An issued jump (codes 6 to 10) gives `next_pc` equal to its fall-through address with `mode_bit`=1, and sets `in_dslot` for exactly the next issued instruction. That instruction gives `next_pc` and `mode_bit` from the held target, and `in_dslot` then clears.
- R9: `pcrel_base` is `pc_cur`, or the held jump address while `in_dslot`=1. It is masked with ~3 for code 12 and with ~7 for code 13.
- R10: `brk_addr` is `pc_cur`, or `pc_cur`-2 while `in_dslot`=1.
- R11: Codes 1 to 10 issued while `in_dslot`=1 raise `illegal`. Such an instruction writes no return address, follows the held target and does not re-arm the slot.
- R12: While `issue_vld`=0 the slot state is held, and `ret_we` and `illegal` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_vld | input | 1 | An instruction is issued this cycle |
| op_code | input | 4 | Decoded operation code |
| is_ext | input | 1 | Extended (32-bit) form with a 16-bit offset |
| imm_field | input | 16 | Raw branch offset field |
| call_hw0 | input | 10 | Low ten bits of the long-call first halfword |
| call_hw1 | input | 16 | Long-call second halfword |
| pc_cur | input | 32 | Address of the issued instruction |
| rs_val | input | 32 | Source register value |
| ra_val | input | 32 | Return-address register value |
| t8_val | input | 32 | Test register value |
| next_pc | output | 32 | Next fetch address, bit 0 clear for jumps |
| mode_bit | output | 1 | Instruction-set mode for the next fetch |
| ret_addr | output | 32 | Return address for calls |
| ret_we | output | 1 | Return-address write enable |
| in_dslot | output | 1 | The presented instruction sits in a delay slot |
| pcrel_base | output | 32 | Base for PC-relative operations |
| brk_addr | output | 32 | Address reported by a break |
| illegal | output | 1 | Control transfer in a delay slot |

## Verification
The bench targets the shuffled call field. A design that swaps the two 5-bit pieces lands in the wrong 2 MB region. It drives negative offsets at each field width, because a sign bit taken from the wrong position turns a backward branch into a far forward one. It inserts idle cycles between a jump and its slot instruction, and sends PC-relative and break instructions through the slot. A unit that drops the slot during idle cycles, or bases these addresses on the slot instruction, would then return addresses that are off by one instruction. It also places a jump inside a slot. A design without the illegal guard would arm a second slot and give the slot instruction's own fall-through address in place of the held target.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

  typedef enum logic [3:0] {
    OP_SEQ   = 4'd0,
    OP_BEQZ  = 4'd1,
    OP_BNEZ  = 4'd2,
    OP_BTEQZ = 4'd3,
    OP_BTNEZ = 4'd4,
    OP_BR    = 4'd5,
    OP_JAL   = 4'd6,
    OP_JALX  = 4'd7,
    OP_JR    = 4'd8,
    OP_JRRA  = 4'd9,
    OP_JALR  = 4'd10,
    OP_BRK   = 4'd11,
    OP_PCW   = 4'd12,
    OP_PCD   = 4'd13
  } bnpc_op_e;

  // operations that open a delay slot
  function automatic logic op_is_jump(input bnpc_op_e op);
    return op inside {OP_JAL, OP_JALX, OP_JR, OP_JRRA, OP_JALR};
  endfunction

  // every control transfer, conditional or not
  function automatic logic op_is_ctrl(input bnpc_op_e op);
    return op inside {OP_BEQZ, OP_BNEZ, OP_BTEQZ, OP_BTNEZ, OP_BR,
                      OP_JAL, OP_JALX, OP_JR, OP_JRRA, OP_JALR};
  endfunction

  // 32-bit long forms
  function automatic logic op_is_long(input bnpc_op_e op, input logic ext);
    return ext || (op == OP_JAL) || (op == OP_JALX);
  endfunction

  function automatic logic op_links(input bnpc_op_e op);
    return op inside {OP_JAL, OP_JALX, OP_JALR};
  endfunction

endpackage

// File: rtl/bnpc_branch_calc.sv
module bnpc_branch_calc
  import bnpc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IMM_W = 16
) (
  input  bnpc_op_e          op,
  input  logic              is_ext,
  input  logic [IMM_W-1:0]  imm,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     rs_val,
  input  logic [AW-1:0]     t8_val,
  output logic [AW-1:0]     nia,
  output logic              br_taken,
  output logic [AW-1:0]     br_tgt
);

  localparam int SHORT_W = 8;
  localparam int UNC_W   = 11;
  localparam logic [AW-1:0] STEP_SHORT = AW'(2);
  localparam logic [AW-1:0] STEP_LONG  = AW'(4);

  // kind: 0 = short conditional, 1 = unconditional, 2 = extended
  function automatic logic [AW-1:0] sx_off(input logic [IMM_W-1:0] raw,
                                           input logic [1:0] kind);
    logic [AW-1:0] v;
    case (kind)
      2'd0:    v = {{(AW-SHORT_W){raw[SHORT_W-1]}}, raw[SHORT_W-1:0]};
      2'd1:    v = {{(AW-UNC_W){raw[UNC_W-1]}}, raw[UNC_W-1:0]};
      default: v = {{(AW-IMM_W){raw[IMM_W-1]}}, raw};
    endcase
    return v;
  endfunction

  function automatic logic [AW-1:0] rel_target(input logic [AW-1:0] base,
                                               input logic [AW-1:0] off);
    return base + {off[AW-2:0], 1'b0};
  endfunction

  logic [1:0]    off_kind;
  logic [AW-1:0] off_val;

  always_comb begin
    nia = pc + (op_is_long(op, is_ext) ? STEP_LONG : STEP_SHORT);
    if (is_ext)            off_kind = 2'd2;
    else if (op == OP_BR)  off_kind = 2'd1;
    else                   off_kind = 2'd0;
    off_val = sx_off(imm, off_kind);
    br_tgt  = rel_target(nia, off_val);
    case (op)
      OP_BEQZ:  br_taken = (rs_val == '0);
      OP_BNEZ:  br_taken = (rs_val != '0);
      OP_BTEQZ: br_taken = (t8_val == '0);
      OP_BTNEZ: br_taken = (t8_val != '0);
      OP_BR:    br_taken = 1'b1;
      default:  br_taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/bnpc_jump_calc.sv
module bnpc_jump_calc
  import bnpc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int HW_W    = 16,
  parameter int SPLIT_W = 5
) (
  input  bnpc_op_e                          op,
  input  logic [AW-1:2*SPLIT_W+HW_W+2]      nia_region,
  input  logic [2*SPLIT_W-1:0]              call_hw0,
  input  logic [HW_W-1:0]                   call_hw1,
  input  logic [AW-1:0]                     rs_val,
  input  logic [AW-1:0]                     ra_val,
  output logic [AW-1:0]                     jmp_tgt
);

  localparam int FIELD_W = 2*SPLIT_W + HW_W;
  localparam int REG_LO  = FIELD_W + 2;

  // first halfword carries the middle slice above the top slice
  function automatic logic [FIELD_W-1:0] unshuffle(input logic [2*SPLIT_W-1:0] h0,
                                                   input logic [HW_W-1:0] h1);
    return {h0[SPLIT_W-1:0], h0[2*SPLIT_W-1:SPLIT_W], h1};
  endfunction

  function automatic logic [AW-1:0] region_target(input logic [AW-1:REG_LO] reg_bits,
                                                  input logic [FIELD_W-1:0] fld,
                                                  input logic mode);
    logic [AW-1:0] t;
    t = {reg_bits, fld, 2'b00};
    t[0] = mode;
    return t;
  endfunction

  logic [FIELD_W-1:0] field;

  always_comb begin
    field = unshuffle(call_hw0, call_hw1);
    case (op)
      OP_JAL:  jmp_tgt = region_target(nia_region, field, 1'b1);
      OP_JALX: jmp_tgt = region_target(nia_region, field, 1'b0);
      OP_JR,
      OP_JALR: jmp_tgt = rs_val;
      OP_JRRA: jmp_tgt = ra_val;
      default: jmp_tgt = '0;
    endcase
  end

endmodule

// File: rtl/bnpc_slot_ctl.sv
module bnpc_slot_ctl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_vld,
  input  logic          start_jump,
  input  logic [AW-1:0] jmp_tgt,
  input  logic [AW-1:0] pc,
  output logic          slot_q,
  output logic [AW-1:0] tgt_q,
  output logic [AW-1:0] jpc_q
);

  logic slot_consume;
  logic slot_arm;

  assign slot_consume = issue_vld && slot_q;
  assign slot_arm     = issue_vld && !slot_q && start_jump;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
      tgt_q  <= '0;
      jpc_q  <= '0;
    end else if (slot_consume) begin
      slot_q <= 1'b0;
    end else if (slot_arm) begin
      slot_q <= 1'b1;
      tgt_q  <= jmp_tgt;
      jpc_q  <= pc;
    end
  end

  // the slot covers a single issued instruction
  assert_slot_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_consume |=> !slot_q);

  // a jump outside a slot arms it
  assert_slot_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && !slot_q && start_jump) |=> slot_q);

  // idle cycles leave the slot alone
  assert_slot_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> $stable(slot_q) && $stable(tgt_q));

endmodule

// File: rtl/bnpc_top.sv
module bnpc_top
  import bnpc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int IMM_W   = 16,
  parameter int HW_W    = 16,
  parameter int SPLIT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_vld,
  input  logic [3:0]           op_code,
  input  logic                 is_ext,
  input  logic [IMM_W-1:0]     imm_field,
  input  logic [2*SPLIT_W-1:0] call_hw0,
  input  logic [HW_W-1:0]      call_hw1,
  input  logic [AW-1:0]        pc_cur,
  input  logic [AW-1:0]        rs_val,
  input  logic [AW-1:0]        ra_val,
  input  logic [AW-1:0]        t8_val,
  output logic [AW-1:0]        next_pc,
  output logic                 mode_bit,
  output logic [AW-1:0]        ret_addr,
  output logic                 ret_we,
  output logic                 in_dslot,
  output logic [AW-1:0]        pcrel_base,
  output logic [AW-1:0]        brk_addr,
  output logic                 illegal
);

  localparam int REG_LO = 2*SPLIT_W + HW_W + 2;
  localparam logic [AW-1:0] WORD_MASK = ~AW'(3);
  localparam logic [AW-1:0] DWORD_MASK = ~AW'(7);
  localparam logic [AW-1:0] HALF_STEP = AW'(2);

  function automatic logic [AW-1:0] pcrel_of(input logic [AW-1:0] base,
                                             input bnpc_op_e op);
    case (op)
      OP_PCW:  return base & WORD_MASK;
      OP_PCD:  return base & DWORD_MASK;
      default: return base;
    endcase
  endfunction

  bnpc_op_e      op;
  logic [AW-1:0] nia;
  logic          br_taken;
  logic [AW-1:0] br_tgt;
  logic [AW-1:0] jmp_tgt;
  logic          slot_q;
  logic [AW-1:0] tgt_q;
  logic [AW-1:0] jpc_q;
  logic          start_jump;
  logic          ctrl_in_slot;

  assign op = bnpc_op_e'(op_code);

  bnpc_branch_calc #(.AW(AW), .IMM_W(IMM_W)) u_branch (
    .op       (op),
    .is_ext   (is_ext),
    .imm      (imm_field),
    .pc       (pc_cur),
    .rs_val   (rs_val),
    .t8_val   (t8_val),
    .nia      (nia),
    .br_taken (br_taken),
    .br_tgt   (br_tgt)
  );

  bnpc_jump_calc #(.AW(AW), .HW_W(HW_W), .SPLIT_W(SPLIT_W)) u_jump (
    .op         (op),
    .nia_region (nia[AW-1:REG_LO]),
    .call_hw0   (call_hw0),
    .call_hw1   (call_hw1),
    .rs_val     (rs_val),
    .ra_val     (ra_val),
    .jmp_tgt    (jmp_tgt)
  );

  assign start_jump = op_is_jump(op);

  bnpc_slot_ctl #(.AW(AW)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_vld  (issue_vld),
    .start_jump (start_jump),
    .jmp_tgt    (jmp_tgt),
    .pc         (pc_cur),
    .slot_q     (slot_q),
    .tgt_q      (tgt_q),
    .jpc_q      (jpc_q)
  );

  assign ctrl_in_slot = slot_q && op_is_ctrl(op);

  always_comb begin
    if (slot_q) begin
      next_pc  = {tgt_q[AW-1:1], 1'b0};
      mode_bit = tgt_q[0];
    end else if (br_taken) begin
      next_pc  = br_tgt;
      mode_bit = 1'b1;
    end else begin
      next_pc  = nia;
      mode_bit = 1'b1;
    end
    ret_addr   = nia + HALF_STEP;
    ret_we     = issue_vld && !slot_q && op_links(op);
    illegal    = issue_vld && ctrl_in_slot;
    in_dslot   = slot_q;
    pcrel_base = pcrel_of(slot_q ? jpc_q : pc_cur, op);
    brk_addr   = slot_q ? (pc_cur - HALF_STEP) : pc_cur;
  end

  assert_illegal_only_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> in_dslot);

  assert_no_link_in_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ret_we |-> !in_dslot);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |-> !ret_we && !illegal);

  assert_word_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PCW) |-> (pcrel_base[1:0] == 2'b00));

  assert_dword_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PCD) |-> (pcrel_base[2:0] == 3'b000));

  assert_seq_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_dslot && !op_is_jump(op)) |-> mode_bit);

endmodule

// File: tb/bnpc_top_tb.sv
`timescale 1ns/1ps
module bnpc_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_vld = 1'b0;
  logic [3:0]  op_code = '0;
  logic        is_ext = 1'b0;
  logic [15:0] imm_field = '0;
  logic [9:0]  call_hw0 = '0;
  logic [15:0] call_hw1 = '0;
  logic [31:0] pc_cur = 32'h0000_1000;
  logic [31:0] rs_val = '0;
  logic [31:0] ra_val = '0;
  logic [31:0] t8_val = '0;
  logic [31:0] next_pc, ret_addr, pcrel_base, brk_addr;
  logic        mode_bit, ret_we, in_dslot, illegal;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  bit        m_slot = 0;
  bit [31:0] m_tgt = 0;
  bit [31:0] m_jpc = 0;

  always #2.5 clk = ~clk;

  bnpc_top u_dut (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .op_code(op_code),
    .is_ext(is_ext), .imm_field(imm_field), .call_hw0(call_hw0),
    .call_hw1(call_hw1), .pc_cur(pc_cur), .rs_val(rs_val), .ra_val(ra_val),
    .t8_val(t8_val), .next_pc(next_pc), .mode_bit(mode_bit),
    .ret_addr(ret_addr), .ret_we(ret_we), .in_dslot(in_dslot),
    .pcrel_base(pcrel_base), .brk_addr(brk_addr), .illegal(illegal)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, compare against the model, advance the model
  task automatic step(input string tag, input bit iv, input int op, input bit ext,
                      input bit [15:0] imm, input bit [9:0] h0, input bit [15:0] h1,
                      input bit [31:0] pc, input bit [31:0] rs,
                      input bit [31:0] ra, input bit [31:0] t8);
    bit [31:0] nia, e_next, e_ret, e_base, e_brk, jt;
    bit e_mode, e_we, e_ill;
    int off;
    @(negedge clk);
    issue_vld = iv; op_code = 4'(op); is_ext = ext; imm_field = imm;
    call_hw0 = h0; call_hw1 = h1; pc_cur = pc; rs_val = rs; ra_val = ra; t8_val = t8;
    #1;
    nia = pc + ((ext || op == 6 || op == 7) ? 32'd4 : 32'd2);
    if (ext) off = int'($signed(imm));
    else if (op == 5) off = int'($signed(imm[10:0]));
    else off = int'($signed(imm[7:0]));
    case (op)
      6: jt = (nia & 32'hF000_0000) | ({h0[4:0], h0[9:5], h1} << 2) | 32'd1;
      7: jt = (nia & 32'hF000_0000) | ({h0[4:0], h0[9:5], h1} << 2);
      8, 10: jt = rs;
      9: jt = ra;
      default: jt = 0;
    endcase
    e_mode = 1; e_next = nia; e_ill = 0;
    e_we = iv && !m_slot && (op == 6 || op == 7 || op == 10);
    if (m_slot) begin
      e_next = m_tgt & ~32'd1;
      e_mode = m_tgt[0];
      e_ill  = iv && op >= 1 && op <= 10;
    end else begin
      if ((op == 1 && rs == 0) || (op == 2 && rs != 0) ||
          (op == 3 && t8 == 0) || (op == 4 && t8 != 0) || op == 5)
        e_next = nia + 32'(off * 2);
    end
    e_ret  = nia + 32'd2;
    e_base = m_slot ? m_jpc : pc;
    if (op == 12) e_base = e_base & ~32'd3;
    if (op == 13) e_base = e_base & ~32'd7;
    e_brk = m_slot ? pc - 32'd2 : pc;
    chk(tag, "next_pc", next_pc, e_next);
    chk(tag, "mode_bit", 32'(mode_bit), 32'(e_mode));
    chk(tag, "ret_we", 32'(ret_we), 32'(e_we));
    chk(tag, "ret_addr", ret_addr, e_ret);
    chk(tag, "in_dslot", 32'(in_dslot), 32'(m_slot));
    chk(tag, "pcrel_base", pcrel_base, e_base);
    chk(tag, "brk_addr", brk_addr, e_brk);
    chk(tag, "illegal", 32'(illegal), 32'(e_ill));
    if (iv) begin
      if (m_slot) m_slot = 0;
      else if (op >= 6 && op <= 10) begin
        m_slot = 1; m_tgt = jt; m_jpc = pc;
      end
    end
  endtask

  task automatic idle(input string tag, input bit [31:0] pc);
    step(tag, 0, 0, 0, 0, 0, 0, pc, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state seen at the ports
    chk("R1", "in_dslot", 32'(in_dslot), 0);
    chk("R1", "ret_we", 32'(ret_we), 0);
    chk("R1", "illegal", 32'(illegal), 0);
    chk("R1", "next_pc", next_pc, 32'h0000_1002);
    chk("R1", "mode_bit", 32'(mode_bit), 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 32'h0000_2000);

    // R2: sequential, short and extended lengths, unknown code
    step("R2", 1, 0, 0, 0, 0, 0, 32'h0000_2000, 0, 0, 0);
    step("R2", 1, 0, 1, 0, 0, 0, 32'h0000_2002, 0, 0, 0);
    step("R2", 1, 15, 0, 0, 0, 0, 32'h0000_2006, 0, 0, 0);

    // R3: operand zero / nonzero, negative and extended offsets
    step("R3", 1, 1, 0, 16'h00F0, 0, 0, 32'h0000_3000, 0, 0, 5);
    step("R3", 1, 1, 0, 16'h0010, 0, 0, 32'h0000_3000, 7, 0, 0);
    step("R3", 1, 2, 0, 16'h007F, 0, 0, 32'h0000_3000, 7, 0, 0);
    step("R3", 1, 2, 1, 16'h8000, 0, 0, 32'h0004_0000, 1, 0, 0);
    step("R3", 1, 1, 1, 16'h1234, 0, 0, 32'h0000_3000, 0, 0, 0);

    // R4: test-register branches ignore the operand
    step("R4", 1, 3, 0, 16'h0020, 0, 0, 32'h0000_4000, 0, 0, 9);
    step("R4", 1, 3, 0, 16'h0020, 0, 0, 32'h0000_4000, 9, 0, 0);
    step("R4", 1, 4, 0, 16'h00E0, 0, 0, 32'h0000_4000, 0, 0, 1);
    step("R4", 1, 4, 0, 16'h00E0, 0, 0, 32'h0000_4000, 3, 0, 0);

    // R5: unconditional, 11-bit sign and extended
    step("R5", 1, 5, 0, 16'h0400, 0, 0, 32'h0000_5000, 0, 0, 0);
    step("R5", 1, 5, 0, 16'hFBFF, 0, 0, 32'h0000_5000, 0, 0, 0);
    step("R5", 1, 5, 1, 16'hFFFE, 0, 0, 32'h0000_5000, 0, 0, 0);

    // R6: long call with shuffled field, then slot with word PC-relative
    step("R6", 1, 6, 0, 0, 10'b10101_00011, 16'hBEEF, 32'h9000_0100, 0, 0, 0);
    step("R9", 1, 12, 0, 0, 0, 0, 32'h9000_0106, 0, 0, 0);
    // R6: mode-switch call, slot holds a break
    step("R6", 1, 7, 0, 0, 10'b00001_11110, 16'h0002, 32'h3FFF_FFFA, 0, 0, 0);
    step("R10", 1, 11, 0, 0, 0, 0, 32'h3FFF_FFFE, 0, 0, 0);

    // R7 / R8: register jump, idle cycles, then slot with doubleword PC-relative
    step("R7", 1, 8, 0, 0, 0, 0, 32'h0000_600E, 32'h0001_2345, 0, 0);
    idle("R12", 32'h0000_6010);
    idle("R12", 32'h0000_6010);
    step("R9", 1, 13, 0, 0, 0, 0, 32'h0000_6010, 0, 0, 0);
    step("R8", 1, 0, 0, 0, 0, 0, 32'h0001_2344, 0, 0, 0);

    // R7: return jump and register call
    step("R7", 1, 9, 0, 0, 0, 0, 32'h0000_7000, 0, 32'h0000_8000, 0);
    step("R8", 1, 0, 0, 0, 0, 0, 32'h0000_7002, 0, 0, 0);
    step("R7", 1, 10, 0, 0, 0, 0, 32'h0000_7100, 32'h0000_9001, 0, 0);
    step("R8", 1, 2, 0, 16'h0004, 0, 0, 32'h0000_7102, 1, 0, 0);

    // R11: jump in a slot is flagged and does not re-arm
    step("R11", 1, 10, 0, 0, 0, 0, 32'h0000_A000, 32'h0000_B000, 0, 0);
    step("R11", 1, 10, 0, 0, 0, 0, 32'h0000_A002, 32'h0000_C000, 0, 0);
    step("R11", 1, 0, 0, 0, 0, 0, 32'h0000_B000, 0, 0, 0);
    step("R11", 1, 6, 0, 0, 10'h3FF, 16'hFFFF, 32'h0000_D000, 0, 0, 0);
    step("R11", 1, 5, 0, 16'h0008, 0, 0, 32'h0000_D004, 0, 0, 0);
    step("R9", 1, 12, 0, 0, 0, 0, 32'h0000_D00E, 0, 0, 0);

    // R2: mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      bit [31:0] rpc;
      rpc = $urandom() & 32'hFFFF_FFFE;
      step("R2", bit'($urandom_range(0, 5) != 0), int'($urandom_range(0, 15)),
           bit'($urandom_range(0, 1)), 16'($urandom()), 10'($urandom()),
           16'($urandom()), rpc,
           ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom(), $urandom(),
           ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom());
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule